// File: doc/BRIEF.md
# Multi-mode pixel event counter

This block is the digital back end of one channel in a hybrid pixel readout array. It takes the raw, asynchronous output of the channel's discriminator and resynchronizes it to the reference clock. The result then drives a single saturating counter. A two-bit mode value sets how the counter behaves. It can stay frozen with the pixel switched off. It can count separate hits. It can accumulate the number of clock cycles spent above threshold. It can also start on the first hit and run until the acquisition window closes, which gives the hit's arrival time measured back from the end of the window.

Counting is gated by a shutter input. The clock edge on which the shutter opens clears the counter for the new window, unless the pixel is switched off. After the shutter closes, a load strobe takes a snapshot of the counter into a shift register, and a shift enable then moves that snapshot out serially with the most significant bit first. A matrix-level sequencer can chain these serial outputs.

Top module: `pix_evt_counter`

## Requirements
- R1: While reset is high and after its release, the counter output and the serial output are zero.
- R2: With mode 2'b00 (off) the counter never changes, including on the edge where the shutter opens.
- R3: With mode 2'b01 (hit count) the counter increases by one for each separate rising excursion of the synchronized discriminator inside the shutter window, whatever the width of the excursion, provided the discriminator is high across at least one clock edge.
- R4: With mode 2'b10 (time over threshold) the counter increases by one on every clock edge on which the synchronized discriminator is high and the shutter is open, so each pulse adds its width in clock cycles.
- R5: With mode 2'b11 (arrival time) the first synchronized rising hit inside the window arms the pixel and adds one. Each later clock edge that still sees the shutter open adds one more. Later hits have no further effect, and neither does the state after the shutter closes.
- R6: The counter stops at its all-ones maximum and never wraps to zero.
- R7: While the shutter is closed the counter holds its value. The clock edge on which the shutter is first seen high clears the counter and the arrival arm flag, in every mode other than off.
- R8: The discriminator passes through a two-flop synchronizer. A rise driven between clock edges reaches the counter on the third following clock edge, and not before.
- R9: A load strobe with the shutter closed copies the counter into the shift register. The serial output presents bit CNT_W-1 after that edge, and each clock edge with the shift enable high moves the next lower bit out.
- R10: A load strobe while the shutter is open is ignored, and the shift register keeps its previous content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, up to 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| disc_async | input | 1 | Raw discriminator output, asynchronous to clk |
| shutter | input | 1 | Acquisition window; counting is allowed while high |
| mode | input | 2 | 00 off, 01 hit count, 10 time over threshold, 11 arrival time |
| load | input | 1 | Snapshot strobe, taken only while the shutter is closed |
| shift_en | input | 1 | Shift the snapshot register one place toward its MSB |
| count_o | output | CNT_W | Registered counter value |
| sout | output | 1 | Serial readout bit (MSB of the snapshot register) |

## Verification
The bench builds the block with a 6-bit counter. With that width the saturation limit of 63 is reached by an 80-cycle pulse over threshold, and a full serial readout takes six shifts, so R6 and R9 fit in short directed scenarios. The synchronizer depth stays at its default of two, which makes the exact three-edge latency of R8 and the two-edge offset in the arrival count of R5 fixed values that the bench can compare against. The default 14-bit width is covered by elaboration and by the bound checker.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_HITS = 2'b01,
    PM_TOT  = 2'b10,
    PM_TOA  = 2'b11
  } pix_mode_e;

endpackage

// File: rtl/pec_sync.sv
// Multi-stage synchronizer for the discriminator, with a registered
// previous value used to find rising excursions.
module pec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pec_core.sv
// Mode-selected saturating counter with shutter gating.
module pec_core
  import pec_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             shutter,
  input  logic             hit_lvl,
  input  logic             hit_rise,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  pix_mode_e mode_e;
  logic      shut_q;
  logic      armed_q;
  logic      open_edge;
  logic      step;
  logic      arm_set;

  assign mode_e    = pix_mode_e'(mode);
  assign open_edge = shutter & ~shut_q;

  always_comb begin
    step    = 1'b0;
    arm_set = 1'b0;
    unique case (mode_e)
      PM_OFF:  step = 1'b0;
      PM_HITS: step = hit_rise;
      PM_TOT:  step = hit_lvl;
      PM_TOA: begin
        arm_set = hit_rise & ~armed_q;
        step    = armed_q | hit_rise;
      end
      default: step = 1'b0;
    endcase
    step = step & shutter & ~open_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) shut_q <= 1'b0;
    else     shut_q <= shutter;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      armed_q <= 1'b0;
    end else if (open_edge) begin
      armed_q <= 1'b0;
      if (mode_e != PM_OFF) cnt <= '0;
    end else begin
      if (arm_set && shutter) armed_q <= 1'b1;
      if (step && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pec_readout.sv
// Snapshot register with MSB-first serial shift.
module pec_readout #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shutter,
  input  logic             load,
  input  logic             shift_en,
  input  logic [CNT_W-1:0] cnt,
  output logic             sout
);

  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)                   snap_q <= '0;
    else if (load && !shutter) snap_q <= cnt;
    else if (shift_en)         snap_q <= {snap_q[CNT_W-2:0], 1'b0};
  end

  assign sout = snap_q[CNT_W-1];

endmodule

// File: rtl/pix_evt_counter.sv
module pix_evt_counter #(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disc_async,
  input  logic             shutter,
  input  logic [1:0]       mode,
  input  logic             load,
  input  logic             shift_en,
  output logic [CNT_W-1:0] count_o,
  output logic             sout
);

  logic hit_lvl;
  logic hit_rise;

  pec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (disc_async),
    .lvl     (hit_lvl),
    .rise    (hit_rise)
  );

  pec_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .shutter  (shutter),
    .hit_lvl  (hit_lvl),
    .hit_rise (hit_rise),
    .cnt      (count_o)
  );

  pec_readout #(.CNT_W(CNT_W)) u_ro (
    .clk      (clk),
    .rst      (rst),
    .shutter  (shutter),
    .load     (load),
    .shift_en (shift_en),
    .cnt      (count_o),
    .sout     (sout)
  );

endmodule

// File: rtl/pix_evt_counter_chk.sv
module pix_evt_counter_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             shutter,
  input logic [1:0]       mode,
  input logic             load,
  input logic             shift_en,
  input logic [CNT_W-1:0] count_o,
  input logic             sout
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (count_o == '0 && !sout));

  // R2
  off_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> $stable(count_o));

  // R7
  closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shutter |=> $stable(count_o));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(shutter) |=> (count_o == $past(count_o) ||
                         {1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count_o == CMAX && !$rose(shutter)) |=> count_o == CMAX);

  // R9
  load_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !shutter) |=> sout == $past(count_o[CNT_W-1]));

  // R10
  load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (load && shutter && !shift_en) |=> $stable(sout));

endmodule

bind pix_evt_counter pix_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shutter  (shutter),
  .mode     (mode),
  .load     (load),
  .shift_en (shift_en),
  .count_o  (count_o),
  .sout     (sout)
);

// File: tb/tb_pix_evt_counter.sv
`timescale 1ns/1ps
module tb_pix_evt_counter;

  localparam int CW  = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          disc_async = 1'b0;
  logic          shutter = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          load = 1'b0;
  logic          shift_en = 1'b0;
  logic [CW-1:0] count_o;
  logic          sout;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pix_evt_counter #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .disc_async(disc_async), .shutter(shutter),
    .mode(mode), .load(load), .shift_en(shift_en),
    .count_o(count_o), .sout(sout)
  );

  task automatic check(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    disc_async = 1'b1;
    repeat (hi) @(negedge clk);
    disc_async = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic open_win();
    shutter = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_win();
    shutter = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(count_o, 0, "R1 count in reset");
    check(sout, 0, "R1 sout in reset");
    rst = 1'b0;
    @(negedge clk);
    check(count_o, 0, "R1 count after reset");
  endtask

  task automatic t_tot();
    mode = 2'b10;
    open_win();
    check(count_o, 0, "R7 cleared on open");
    disc_async = 1'b1;
    @(negedge clk);
    check(count_o, 0, "R8 edge 1");
    @(negedge clk);
    check(count_o, 0, "R8 edge 2");
    @(negedge clk);
    check(count_o, 1, "R8 edge 3");
    repeat (2) @(negedge clk);
    disc_async = 1'b0;
    repeat (4) @(negedge clk);
    check(count_o, 5, "R4 first pulse");
    pulse(3, 4);
    check(count_o, 8, "R4 second pulse");
    close_win();
  endtask

  task automatic t_hits();
    mode = 2'b01;
    open_win();
    check(count_o, 0, "R7 cleared on reopen");
    repeat (4) pulse(3, 3);
    pulse(1, 2);
    pulse(4, 2);
    pulse(2, 5);
    check(count_o, 7, "R3 hit count");
    close_win();
    repeat (3) pulse(2, 3);
    check(count_o, 7, "R7 closed window ignores hits");
  endtask

  task automatic t_off();
    mode = 2'b00;
    open_win();
    repeat (3) pulse(3, 3);
    check(count_o, 7, "R2 off mode frozen");
    close_win();
  endtask

  task automatic t_toa();
    mode = 2'b11;
    open_win();
    repeat (3) @(negedge clk);
    check(count_o, 0, "R5 idle before hit");
    pulse(2, 2);
    pulse(2, 2);
    pulse(2, 2);
    shutter = 1'b0;
    repeat (4) @(negedge clk);
    check(count_o, 10, "R5 arrival count");
    pulse(2, 3);
    check(count_o, 10, "R5 stop after close");
  endtask

  task automatic do_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic shift_check(input int exp, input string req);
    for (int i = CW - 1; i >= 0; i--) begin
      check(sout, (exp >> i) & 1, req);
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic t_readout();
    do_load();
    shift_check(10, "R9 serial readout");
    do_load();
    check(sout, 0, "R9 MSB of 10");
  endtask

  task automatic t_sat();
    mode = 2'b10;
    open_win();
    pulse(80, 4);
    check(count_o, MAXV, "R6 saturate");
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check(count_o, MAXV, "R6 hold at max");
    close_win();
    shift_check(10, "R10 load ignored while open");
    do_load();
    shift_check(MAXV, "R9 readout of max");
  endtask

  initial begin
    #(20.0 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_tot();
    t_hits();
    t_off();
    t_toa();
    t_readout();
    t_sat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule